// File: doc/BRIEF.md
# Interrupt Enable, Pending and Level Register Unit

This block holds the interrupt registers of a serial port controller. It sits on a simple 32-bit register bus (address, write strobe, write data, combinational read data) and receives one event input per interrupt source. Software never writes the interrupt mask directly. It sets mask bits through one write-only register and clears them through another. The mask can be read at its own address.

Each rising edge of an event whose mask bit is 1 latches a pending bit. Software clears a pending bit by writing 1 to it. A single registered interrupt line is high while any pending bit is also enabled in the mask. A separate level view reports the live state of four flow-related event inputs, whatever the mask holds. This lets polling code see FIFO levels with the interrupt for them turned off.

Offsets used by the unit: 0x08 mask-set, 0x0C mask-clear, 0x10 mask readback, 0x14 pending, 0x2C level view. Any other offset reads 0 and is not written. Event bit positions are shared by the mask and pending registers. Bit 0 is receive trigger, bit 1 receive empty, bit 2 receive full, bit 3 transmit empty, bit 4 transmit full, bit 5 overrun, bit 6 framing error, bit 7 parity error and bit 8 receive timeout.

Top module: `sci_irq_unit`

## Requirements
- R1: After synchronous reset the mask, the pending register and the interrupt output are all 0.
- R2: A bus write to offset 0x08 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value. The new mask is readable at offset 0x10 one clock later.
- R3: A bus write to offset 0x0C clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value. When set and clear writes to the same bit come in consecutive cycles, the later write decides the bit.
- R4: Reads of offsets 0x08 and 0x0C return 0. A write to offset 0x10 or 0x2C changes neither the mask nor the pending register.
- R5: A pending bit (read at 0x14) becomes 1 one clock after a rising edge of its event input, but only if its mask bit is 1 on that edge. A rising edge while the mask bit is 0 leaves the pending bit at 0, and so does turning the mask on later while the input stays high.
- R6: A bus write to offset 0x14 clears every pending bit whose data bit is 1 and leaves the others unchanged.
- R7: When a qualified rising edge and a clearing write hit the same pending bit in the same cycle, the bit ends up 1.
- R8: A read of offset 0x2C returns the live levels of event inputs 0, 1, 3 and 4 at bits 0, 1, 3 and 4, independent of the mask. All other bits of this view read 0.
- R9: Only bits 12:0 of the mask are writable. Data bits 31:13 are ignored, and mask reads show 0 above bit 12. Pending bits 12:9 have no source and always read 0.
- R10: The interrupt output is a register. It is 1 one clock after any bit is 1 in both the pending register and the mask, and 0 one clock after no such bit exists.
- R11: Clearing a mask bit does not clear its pending bit. The pending bit stays readable, and it stops contributing to the interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| evt_in | input | 9 | Event levels, one per interrupt source |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A wrong mask bit shows up on the very next read of 0x10. It also shows at the interrupt output one clock after a pending bit that should have been gated, or should not have been, is present. A pending bit that was missed, set spuriously or cleared wrongly is visible at 0x14 in the cycle after the offending edge or write. It also reaches the interrupt line one cycle later. The bench therefore reads the mask and the pending register after every random write and compares the interrupt line every cycle. A missed edge or a set-versus-clear priority error is then caught within two clocks of the cause.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;

    // Default geometry of the interrupt register set
    localparam int unsigned BUS_W_DEF   = 32;
    localparam int unsigned ADDR_W_DEF  = 8;
    localparam int unsigned VALID_W_DEF = 13;
    localparam int unsigned NUM_EVT_DEF = 9;

    // Byte offsets of the registers
    localparam logic [7:0] OFS_MASK_SET = 8'h08;
    localparam logic [7:0] OFS_MASK_CLR = 8'h0C;
    localparam logic [7:0] OFS_MASK_RD  = 8'h10;
    localparam logic [7:0] OFS_PENDING  = 8'h14;
    localparam logic [7:0] OFS_LEVELS   = 8'h2C;

    // Which register a bus access selects
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_SET,
        SEL_MASK_CLR,
        SEL_MASK_RD,
        SEL_PENDING,
        SEL_LEVELS
    } reg_sel_e;

    // Write actions produced by the decoder
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic pend_clr;
    } wr_action_t;

    // Event positions that the raw level view exposes
    function automatic logic level_visible(int unsigned idx);
        return (idx == 0) || (idx == 1) || (idx == 3) || (idx == 4);
    endfunction

endpackage

// File: rtl/sci_irq_decode.sv
module sci_irq_decode
    import sci_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_sel_e          sel,
    output wr_action_t        act
);

    always_comb begin
        if (addr == ADDR_W'(OFS_MASK_SET))      sel = SEL_MASK_SET;
        else if (addr == ADDR_W'(OFS_MASK_CLR)) sel = SEL_MASK_CLR;
        else if (addr == ADDR_W'(OFS_MASK_RD))  sel = SEL_MASK_RD;
        else if (addr == ADDR_W'(OFS_PENDING))  sel = SEL_PENDING;
        else if (addr == ADDR_W'(OFS_LEVELS))   sel = SEL_LEVELS;
        else                                    sel = SEL_NONE;
    end

    always_comb begin
        act          = '0;
        act.mask_set = wr && (sel == SEL_MASK_SET);
        act.mask_clr = wr && (sel == SEL_MASK_CLR);
        act.pend_clr = wr && (sel == SEL_PENDING);
    end

endmodule

// File: rtl/sci_irq_mask.sv
module sci_irq_mask
    import sci_irq_pkg::*;
#(
    parameter int unsigned VALID_W = VALID_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_action_t         act,
    input  logic [VALID_W-1:0] bits,
    output logic [VALID_W-1:0] mask_q
);

    logic [VALID_W-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (act.mask_set) mask_d = mask_q | bits;
        if (act.mask_clr) mask_d = mask_q & ~bits;
    end

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '0;
        else     mask_q <= mask_d;
    end

endmodule

// File: rtl/sci_irq_pending.sv
module sci_irq_pending
    import sci_irq_pkg::*;
#(
    parameter int unsigned NUM_EVT = NUM_EVT_DEF,
    parameter int unsigned VALID_W = VALID_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [VALID_W-1:0] mask,
    input  logic               clr_en,
    input  logic [VALID_W-1:0] clr_bits,
    output logic [VALID_W-1:0] pend_q
);

    for (genvar i = 0; i < VALID_W; i++) begin : g_bit
        if (i < NUM_EVT) begin : g_src
            logic prev_q;
            logic bit_q;
            logic rise;
            logic wipe;

            assign rise = evt[i] & ~prev_q & mask[i];
            assign wipe = clr_en & clr_bits[i];

            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= 1'b0;
                    bit_q  <= 1'b0;
                end else begin
                    prev_q <= evt[i];
                    // a new edge outranks a simultaneous clear
                    if (rise)      bit_q <= 1'b1;
                    else if (wipe) bit_q <= 1'b0;
                end
            end

            assign pend_q[i] = bit_q;
        end else begin : g_nosrc
            assign pend_q[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sci_irq_rdmux.sv
module sci_irq_rdmux
    import sci_irq_pkg::*;
#(
    parameter int unsigned BUS_W   = BUS_W_DEF,
    parameter int unsigned NUM_EVT = NUM_EVT_DEF,
    parameter int unsigned VALID_W = VALID_W_DEF
) (
    input  reg_sel_e           sel,
    input  logic [VALID_W-1:0] mask,
    input  logic [VALID_W-1:0] pend,
    input  logic [NUM_EVT-1:0] evt,
    output logic [BUS_W-1:0]   rdata
);

    logic [BUS_W-1:0] level_view;

    for (genvar i = 0; i < BUS_W; i++) begin : g_lvl
        if (i < NUM_EVT && level_visible(i)) begin : g_on
            assign level_view[i] = evt[i];
        end else begin : g_off
            assign level_view[i] = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_MASK_RD: rdata = BUS_W'(mask);
            SEL_PENDING: rdata = BUS_W'(pend);
            SEL_LEVELS:  rdata = level_view;
            default:     rdata = '0;
        endcase
    end

endmodule

// File: rtl/sci_irq_unit.sv
module sci_irq_unit
    import sci_irq_pkg::*;
#(
    parameter int unsigned BUS_W   = BUS_W_DEF,
    parameter int unsigned ADDR_W  = ADDR_W_DEF,
    parameter int unsigned VALID_W = VALID_W_DEF,
    parameter int unsigned NUM_EVT = NUM_EVT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic              irq_out
);

    localparam int unsigned FIELD_W = (VALID_W < BUS_W) ? VALID_W : BUS_W;

    reg_sel_e           sel;
    wr_action_t         act;
    logic [VALID_W-1:0] wbits;
    logic [VALID_W-1:0] mask_q;
    logic [VALID_W-1:0] pend_q;
    logic               irq_q;

    assign wbits = VALID_W'(bus_wdata[FIELD_W-1:0]);

    sci_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .sel  (sel),
        .act  (act)
    );

    sci_irq_mask #(.VALID_W(VALID_W)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .act    (act),
        .bits   (wbits),
        .mask_q (mask_q)
    );

    sci_irq_pending #(.NUM_EVT(NUM_EVT), .VALID_W(VALID_W)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_in),
        .mask     (mask_q),
        .clr_en   (act.pend_clr),
        .clr_bits (wbits),
        .pend_q   (pend_q)
    );

    sci_irq_rdmux #(.BUS_W(BUS_W), .NUM_EVT(NUM_EVT), .VALID_W(VALID_W)) u_rd (
        .sel   (sel),
        .mask  (mask_q),
        .pend  (pend_q),
        .evt   (evt_in),
        .rdata (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(pend_q & mask_q);
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/sci_irq_unit_chk.sv
module sci_irq_unit_chk #(
    parameter int unsigned BUS_W   = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned VALID_W = 13,
    parameter int unsigned NUM_EVT = 9
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [BUS_W-1:0]   bus_wdata,
    input logic [BUS_W-1:0]   bus_rdata,
    input logic [NUM_EVT-1:0] evt_in,
    input logic               irq_out,
    input logic [VALID_W-1:0] mask_q,
    input logic [VALID_W-1:0] pend_q
);

    logic [NUM_EVT-1:0] evt_d;
    logic [NUM_EVT-1:0] qual_rise;
    logic [VALID_W-1:0] wv;
    logic               wr_set, wr_clr, wr_pend, mask_wr;

    always_ff @(posedge clk) begin
        if (rst) evt_d <= '0;
        else     evt_d <= evt_in;
    end

    assign qual_rise = evt_in & ~evt_d & mask_q[NUM_EVT-1:0];
    assign wv        = bus_wdata[VALID_W-1:0];
    assign wr_set    = bus_wr && (bus_addr == ADDR_W'(8'h08));
    assign wr_clr    = bus_wr && (bus_addr == ADDR_W'(8'h0C));
    assign wr_pend   = bus_wr && (bus_addr == ADDR_W'(8'h14));
    assign mask_wr   = wr_set || wr_clr;

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_out); // R1

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((mask_q & $past(wv)) == $past(wv))); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((mask_q & $past(wv)) == '0)); // R3

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q)); // R4

    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr == ADDR_W'(8'h08)) || (bus_addr == ADDR_W'(8'h0C))) |-> (bus_rdata == '0)); // R4

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (|qual_rise) |=> ((pend_q[NUM_EVT-1:0] & $past(qual_rise)) == $past(qual_rise))); // R5 R7

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_pend |=> ((pend_q[NUM_EVT-1:0] & $past(wv[NUM_EVT-1:0] & ~qual_rise)) == '0)); // R6

    AST_NO_SILENT_SET: assert property (@(posedge clk) disable iff (rst)
        !(|qual_rise) |=> ((pend_q & ~$past(pend_q)) == '0)); // R5

    AST_LEVEL_VIEW: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(8'h2C)) |->
        (bus_rdata[4:0] == {evt_in[4], evt_in[3], 1'b0, evt_in[1], evt_in[0]})); // R8

    AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (rst)
        pend_q[VALID_W-1:NUM_EVT] == '0); // R9

    AST_IRQ_RISES: assert property (@(posedge clk) disable iff (rst)
        (|(pend_q & mask_q)) |=> irq_out); // R10

    AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (rst)
        !(|(pend_q & mask_q)) |=> !irq_out); // R10 R11

endmodule

bind sci_irq_unit sci_irq_unit_chk #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .VALID_W(VALID_W), .NUM_EVT(NUM_EVT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_in    (evt_in),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .pend_q    (pend_q)
);

// File: tb/sci_irq_unit_test.sv
`timescale 1ns/1ps
module sci_irq_unit_test;

    localparam logic [7:0] A_SET = 8'h08, A_CLR = 8'h0C, A_MRD = 8'h10;
    localparam logic [7:0] A_PND = 8'h14, A_LVL = 8'h2C, A_CTL = 8'h00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  ev = '0;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sci_irq_unit uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(ev), .irq_out(irq_out)
    );

    // Reference state, built from the requirements
    logic [12:0] m_mask, m_pend;
    logic [8:0]  m_prev;
    logic        m_irq;

    always @(posedge clk) begin
        if (rst) begin
            m_mask <= '0; m_pend <= '0; m_prev <= '0; m_irq <= 1'b0;
        end else begin
            logic [12:0] rise, wipe, nm;
            rise = {4'b0, ev & ~m_prev & m_mask[8:0]};
            wipe = (bus_wr && bus_addr == A_PND) ? bus_wdata[12:0] : 13'b0;
            nm = m_mask;
            if (bus_wr && bus_addr == A_SET) nm = m_mask | bus_wdata[12:0];
            if (bus_wr && bus_addr == A_CLR) nm = m_mask & ~bus_wdata[12:0];
            m_pend <= (m_pend & ~wipe) | rise;
            m_mask <= nm;
            m_prev <= ev;
            m_irq  <= |(m_pend & m_mask);
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            A_MRD:   return {19'b0, m_mask};
            A_PND:   return {19'b0, m_pend};
            A_LVL:   return {27'b0, ev[4], ev[3], 1'b0, ev[1], ev[0]};
            default: return 32'b0;
        endcase
    endfunction

    task automatic drive(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [8:0] e);
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; ev = e;
        @(posedge clk);
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        exp = exp_read(a);
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        @(posedge clk);
    endtask

    task automatic irq_chk(input string tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = A_CTL;
        #1;
        n_chk++;
        if (irq_out !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_out, m_irq);
        end
        @(posedge clk);
    endtask

    task automatic val_chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        @(negedge clk); #1;
        val_chk({31'b0, irq_out}, 32'd0, "R1 irq after reset");
        rd_chk(A_MRD, "R1 mask after reset");
        rd_chk(A_PND, "R1 pending after reset");

        // R2 set writes
        drive(1, A_SET, 32'h0A5, 9'h0);
        rd_chk(A_MRD, "R2 set first");
        val_chk(bus_rdata, 32'h0A5, "R2 mask value");
        drive(1, A_SET, 32'h100, 9'h0);
        rd_chk(A_MRD, "R2 set keeps zeros");

        // R4 write-only reads and ignored writes
        rd_chk(A_SET, "R4 set reg reads zero");
        rd_chk(A_CLR, "R4 clear reg reads zero");
        drive(1, A_MRD, 32'h1FFF, 9'h0);
        drive(1, A_LVL, 32'h1FFF, 9'h0);
        rd_chk(A_MRD, "R4 mask write ignored");
        rd_chk(A_PND, "R4 pending untouched");

        // R3 clear writes and back-to-back ordering
        drive(1, A_CLR, 32'h005, 9'h0);
        rd_chk(A_MRD, "R3 clear partial");
        val_chk(bus_rdata, 32'h1A0, "R3 mask value");
        drive(1, A_SET, 32'h004, 9'h0);
        drive(1, A_CLR, 32'h004, 9'h0);
        rd_chk(A_MRD, "R3 set then clear");
        drive(1, A_CLR, 32'h008, 9'h0);
        drive(1, A_SET, 32'h008, 9'h0);
        rd_chk(A_MRD, "R3 clear then set");

        // R9 bits above the valid field
        drive(1, A_SET, 32'hFFFF_FFFF, 9'h0);
        rd_chk(A_MRD, "R9 mask width");
        val_chk(bus_rdata, 32'h1FFF, "R9 mask value");
        drive(1, A_CLR, 32'hFFFF_FFFF, 9'h0);
        rd_chk(A_MRD, "R9 clear all");

        // R5 qualified and unqualified edges
        drive(1, A_SET, 32'h001, 9'h0);
        drive(0, A_CTL, 32'h0, 9'h003);
        rd_chk(A_PND, "R5 edge latches masked-in bit only");
        val_chk(bus_rdata, 32'h001, "R5 pending value");
        drive(1, A_SET, 32'h002, 9'h003);
        rd_chk(A_PND, "R5 late enable no edge");
        val_chk(bus_rdata, 32'h001, "R5 still only bit0");

        // R10 interrupt line
        irq_chk("R10 irq high");
        val_chk({31'b0, irq_out}, 32'd1, "R10 irq value");

        // R11 mask removal keeps pending
        drive(1, A_CLR, 32'h003, 9'h003);
        irq_chk("R11 irq drops");
        rd_chk(A_PND, "R11 pending kept");
        val_chk(bus_rdata, 32'h001, "R11 pending value");

        // R6 write-one clear
        drive(1, A_PND, 32'h000, 9'h0);
        rd_chk(A_PND, "R6 zero write keeps");
        drive(1, A_PND, 32'h001, 9'h0);
        rd_chk(A_PND, "R6 one clears");

        // R7 set beats clear
        drive(1, A_SET, 32'h010, 9'h0);
        drive(1, A_PND, 32'h010, 9'h010);
        rd_chk(A_PND, "R7 set wins");
        val_chk(bus_rdata, 32'h010, "R7 pending value");

        // R8 raw level view
        drive(1, A_CLR, 32'h1FFF, 9'h1FF);
        rd_chk(A_LVL, "R8 all high");
        val_chk(bus_rdata, 32'h01B, "R8 view value");
        drive(0, A_CTL, 32'h0, 9'h1E4);
        rd_chk(A_LVL, "R8 hidden bits");
        drive(0, A_CTL, 32'h0, 9'h00A);
        rd_chk(A_LVL, "R8 mixed");
        drive(1, A_PND, 32'h1FFF, 9'h0);

        // Random phase covering R2 R3 R5 R6 R7 R10
        for (int k = 0; k < 3000; k++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [8:0]  e;
            case ($urandom_range(0, 5))
                0: a = A_SET;
                1: a = A_CLR;
                2: a = A_PND;
                3: a = A_MRD;
                4: a = A_LVL;
                default: a = A_CTL;
            endcase
            d = ($urandom_range(0, 3) == 0) ? $urandom : (32'h1 << $urandom_range(0, 12));
            e = ($urandom_range(0, 2) == 0) ? 9'($urandom) : ev;
            drive($urandom_range(0, 3) != 0, a, d, e);
            if (k % 3 == 0) rd_chk(A_MRD, "R2 R3 random mask");
            if (k % 3 == 1) rd_chk(A_PND, "R5 R6 R7 random pending");
            if (k % 3 == 2) irq_chk("R10 random irq");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule